// File: doc/BRIEF.md
# Requester-to-Stream ID Mapping Table

This block holds a small table that translates the 16-bit requester ID of an inbound PCIe transaction into the stream ID an IOMMU uses to pick a translation context. Software fills the table through a simple register port. Each slot is a 32-bit word that carries an enable flag, a stream ID and the requester ID it applies to. In parallel, a lookup port accepts a requester ID and, one cycle later, reports whether any enabled slot claims it and, if so, which stream ID applies.

The address space always spans a fixed maximum number of slots. Only the first `IMPL_SLOTS` slots are backed by storage. The slots above them read as zero and drop writes. Software can therefore size the table by writing a test word to each slot in turn and checking whether it reads back unchanged. A lookup that finds no enabled slot for its requester raises a one-cycle mapping-error pulse, which a neighbouring interrupt unit latches.

Top module: `rsid_map_table`

## Requirements
- R1: After reset every slot reads as zero, and therefore every slot is disabled. All outputs are low.
- R2: A write stores the 32-bit word in slot `reg_idx`: bit 31 is the enable flag, bits 30:16 the 15-bit stream ID, and bits 15:0 the requester ID. A read raises `reg_rvalid` in the next cycle, with `reg_rdata` holding the slot word. When `reg_rvalid` is low, `reg_rdata` is zero.
- R3: Slots with index `IMPL_SLOTS` or higher ignore writes and read as zero. When a test word is written to each slot and read back, it survives in exactly `IMPL_SLOTS` slots.
- R4: A lookup request raises `lk_done` in the next cycle. If an enabled slot holds the same 16-bit requester ID, `lk_hit` is 1 and `lk_sid` is that slot's stream ID.
- R5: A slot with bit 31 clear never matches, even when its requester ID field equals the input. Writing zero to a slot removes its mapping.
- R6: When several enabled slots match, the slot with the lowest index provides the stream ID.
- R7: A lookup that finds no match returns `lk_hit`=0 and `lk_sid`=0, and pulses `map_err` for exactly that one cycle. `map_err` never rises without a lookup in the previous cycle.
- R8: A lookup or read in the same cycle as a write sees the table as it was before that write. The next lookup or read sees the new contents.
- R9: The requester ID compares all 16 bits: bus number in bits 15:8, device in bits 7:3 and function in bits 2:0. Two IDs that differ only in the function number map independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write the slot selected by `reg_idx` |
| reg_rd_en | input | 1 | Read the slot selected by `reg_idx` |
| reg_idx | input | 6 | Slot index for read and write |
| reg_wdata | input | 32 | Slot word to write |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd_en` |
| reg_rdata | output | 32 | Slot word read back |
| lk_req | input | 1 | Lookup request |
| lk_rid | input | 16 | Requester ID to look up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | An enabled slot matched |
| lk_sid | output | 15 | Stream ID of the lowest matching slot |
| map_err | output | 1 | One-cycle pulse on a lookup miss |

## Verification
A register write and a lookup, or a write and a read, can fall in the same clock cycle. In that case the lookup or read must reflect the slot contents from before the write. The bench provokes this by enabling a slot while the same requester is being looked up, and then by disabling the slot while it is being read. It judges the result against a behavioural copy of the table that answers each request first and only then applies the write. The expected result is a miss followed by a hit in the first case, and the old word followed by zero in the second.

// File: rtl/rsid_pkg.sv
package rsid_pkg;
  localparam int RID_W   = 16;
  localparam int SID_W   = 15;
  localparam int ENTRY_W = 1 + SID_W + RID_W;

  typedef struct packed {
    logic             valid;
    logic [SID_W-1:0] sid;
    logic [RID_W-1:0] rid;
  } rsid_entry_t;

  // Requester ID: bus in the top byte, then device (5 bits), then function (3 bits).
  function automatic logic [RID_W-1:0] make_rid(logic [7:0] bus, logic [4:0] dev,
                                                 logic [2:0] fn);
    return {bus, dev, fn};
  endfunction

  function automatic logic slot_claims(rsid_entry_t e, logic [RID_W-1:0] rid);
    return e.valid && (e.rid == rid);
  endfunction
endpackage

// File: rtl/rsid_entry_store.sv
module rsid_entry_store
  import rsid_pkg::*;
#(
  parameter int NUM_SLOTS  = 64,
  parameter int IMPL_SLOTS = 40,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  rsid_entry_t                  wr_data,
  output rsid_entry_t [NUM_SLOTS-1:0]  slots
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i < IMPL_SLOTS) begin : g_impl
      rsid_entry_t q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (wr_en && (wr_idx == IDX_W'(i))) q <= wr_data;
      end
      assign slots[i] = q;
    end else begin : g_void
      assign slots[i] = '0;
    end
  end
endmodule

// File: rtl/rsid_match.sv
module rsid_match
  import rsid_pkg::*;
#(
  parameter int NUM_SLOTS = 64
) (
  input  rsid_entry_t [NUM_SLOTS-1:0] slots,
  input  logic [RID_W-1:0]            rid,
  output logic [NUM_SLOTS-1:0]        hit_vec,
  output logic                        hit,
  output logic [SID_W-1:0]            sid
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cmp
    assign hit_vec[i] = slot_claims(slots[i], rid);
  end

  // Walk from the top down so that the lowest matching index is written last.
  always_comb begin
    hit = 1'b0;
    sid = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit = 1'b1;
        sid = slots[i].sid;
      end
    end
  end
endmodule

// File: rtl/rsid_map_table.sv
module rsid_map_table
  import rsid_pkg::*;
#(
  parameter int NUM_SLOTS  = 64,
  parameter int IMPL_SLOTS = 40,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [IDX_W-1:0]   reg_idx,
  input  logic [ENTRY_W-1:0] reg_wdata,
  output logic               reg_rvalid,
  output logic [ENTRY_W-1:0] reg_rdata,
  input  logic               lk_req,
  input  logic [RID_W-1:0]   lk_rid,
  output logic               lk_done,
  output logic               lk_hit,
  output logic [SID_W-1:0]   lk_sid,
  output logic               map_err
);
  rsid_entry_t [NUM_SLOTS-1:0] slots;
  logic [NUM_SLOTS-1:0]        slot_hit_vec;
  logic                        hit_now;
  logic [SID_W-1:0]            sid_now;
  logic                        miss_now;

  rsid_entry_store #(.NUM_SLOTS(NUM_SLOTS), .IMPL_SLOTS(IMPL_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_idx(reg_idx),
    .wr_data(rsid_entry_t'(reg_wdata)), .slots(slots)
  );

  rsid_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .slots(slots), .rid(lk_rid), .hit_vec(slot_hit_vec), .hit(hit_now), .sid(sid_now)
  );

  assign miss_now = lk_req && !hit_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done    <= 1'b0;
      lk_hit     <= 1'b0;
      lk_sid     <= '0;
      map_err    <= 1'b0;
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      lk_done    <= lk_req;
      lk_hit     <= lk_req && hit_now;
      lk_sid     <= (lk_req && hit_now) ? sid_now : '0;
      map_err    <= miss_now;
      reg_rvalid <= reg_rd_en;
      reg_rdata  <= reg_rd_en ? ENTRY_W'(slots[reg_idx]) : '0;
    end
  end
endmodule

// File: rtl/rsid_map_checker.sv
module rsid_map_checker #(
  parameter int NUM_SLOTS  = 64,
  parameter int IMPL_SLOTS = 40,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_rd_en,
  input logic [IDX_W-1:0]     reg_idx,
  input logic                 reg_rvalid,
  input logic [31:0]          reg_rdata,
  input logic                 lk_req,
  input logic                 lk_done,
  input logic                 lk_hit,
  input logic [14:0]          lk_sid,
  input logic                 map_err,
  input logic [NUM_SLOTS-1:0] slot_hit_vec
);
  p_rvalid_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> reg_rvalid);

  p_void_slot_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && (int'(reg_idx) >= IMPL_SLOTS)) |=> (reg_rdata == '0));

  p_done_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_done);

  p_any_claim_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && (slot_hit_vec != '0)) |=> lk_hit);

  p_err_only_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    map_err |-> (lk_done && !lk_hit && (lk_sid == '0)));

  p_err_needs_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !map_err);

  p_hit_implies_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_done);
endmodule

bind rsid_map_table rsid_map_checker #(.NUM_SLOTS(NUM_SLOTS), .IMPL_SLOTS(IMPL_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rd_en(reg_rd_en), .reg_idx(reg_idx),
  .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_done(lk_done),
  .lk_hit(lk_hit), .lk_sid(lk_sid), .map_err(map_err), .slot_hit_vec(slot_hit_vec)
);

// File: tb/test_rsid_map_table.sv
module test_rsid_map_table;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT      = 64;
  localparam int NIMPL      = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0, lk = 1'b0;
  logic [5:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [15:0] lrid = '0;
  logic        rvalid, done, hit, err;
  logic [31:0] rdata;
  logic [14:0] sid;

  int checks = 0, errors = 0, probe_hits = 0;
  bit finished = 0;
  logic [31:0] model [NSLOT];

  always #(CLK_PERIOD/2) clk = ~clk;

  rsid_map_table #(.NUM_SLOTS(NSLOT), .IMPL_SLOTS(NIMPL)) i_rsid_map_table (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_rd_en(rd), .reg_idx(idx),
    .reg_wdata(wdata), .reg_rvalid(rvalid), .reg_rdata(rdata), .lk_req(lk),
    .lk_rid(lrid), .lk_done(done), .lk_hit(hit), .lk_sid(sid), .map_err(err)
  );

  function automatic logic [15:0] rid(int bus, int dev, int fn);
    return 16'(bus * 256 + dev * 8 + fn);
  endfunction

  function automatic logic [31:0] word(bit en, int s, logic [15:0] r);
    return (en ? 32'h8000_0000 : 32'h0) | (32'(s & 16'h7fff) << 16) | 32'(r);
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: answer requests from the pre-write model, then apply the write.
  task automatic step(string tag);
    logic e_rv, e_done, e_hit, e_err;
    logic [31:0] e_rd;
    logic [14:0] e_sid;
    @(posedge clk);
    e_rv = rd;
    e_rd = rd ? model[idx] : 32'h0;
    e_done = lk; e_hit = 0; e_sid = 0;
    if (lk) begin
      for (int i = 0; i < NSLOT; i++)
        if (!e_hit && model[i][31] && model[i][15:0] == lrid) begin
          e_hit = 1; e_sid = model[i][30:16];
        end
    end
    e_err = lk && !e_hit;
    if (wr && idx < NIMPL) model[idx] = wdata;
    #(CLK_PERIOD/4);
    check(tag, "rvalid", 32'(rvalid), 32'(e_rv));
    check(tag, "rdata", rdata, e_rd);
    check(tag, "done", 32'(done), 32'(e_done));
    check(tag, "hit", 32'(hit), 32'(e_hit));
    check(tag, "sid", 32'(sid), 32'(e_sid));
    check(tag, "map_err", 32'(err), 32'(e_err));
    @(negedge clk);
    wr = 0; rd = 0; lk = 0;
  endtask

  task automatic do_write(int i, logic [31:0] d, string tag);
    wr = 1; idx = 6'(i); wdata = d; step(tag);
  endtask
  task automatic do_read(int i, string tag);
    rd = 1; idx = 6'(i); step(tag);
  endtask
  task automatic do_lookup(logic [15:0] r, string tag);
    lk = 1; lrid = r; step(tag);
  endtask

  initial begin
    for (int i = 0; i < NSLOT; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents and idle outputs
    step("R1");
    for (int i = 0; i < NSLOT; i++) do_read(i, "R1");
    do_lookup(16'h0000, "R1");

    // R2: store and read back assorted words
    do_write(0, word(1, 16'h0123, rid(1, 0, 0)), "R2");
    do_write(1, word(1, 16'h7fff, rid(2, 31, 7)), "R2");
    do_write(7, 32'h1234_5678, "R2");
    do_write(39, word(1, 16'h2222, rid(255, 1, 1)), "R2");
    do_read(0, "R2"); do_read(1, "R2"); do_read(7, "R2"); do_read(39, "R2");

    // R3: unbacked slots drop writes; sizing probe finds NIMPL slots
    do_write(40, 32'hffff_ffff, "R3");
    do_write(63, 32'h8001_0001, "R3");
    do_read(40, "R3"); do_read(63, "R3");
    do_lookup(16'h0001, "R3");
    for (int i = 0; i < NSLOT; i++) begin
      logic [31:0] keep;
      keep = model[i];
      do_write(i, 32'h000b_ad1d, "R3");
      rd = 1; idx = 6'(i);
      @(posedge clk); #(CLK_PERIOD/4);
      if (rvalid && rdata == 32'h000b_ad1d) probe_hits++;
      @(negedge clk); rd = 0;
      do_write(i, keep, "R3");
    end
    check("R3", "probe_count", 32'(probe_hits), 32'(NIMPL));

    // R4, R9: hits, including IDs differing only in function number
    do_lookup(rid(1, 0, 0), "R4");
    do_lookup(rid(2, 31, 7), "R4");
    do_lookup(rid(255, 1, 1), "R4");
    do_write(2, word(1, 16'h0aaa, rid(9, 4, 2)), "R9");
    do_write(3, word(1, 16'h0bbb, rid(9, 4, 3)), "R9");
    do_lookup(rid(9, 4, 2), "R9");
    do_lookup(rid(9, 4, 3), "R9");
    do_lookup(rid(9, 4, 4), "R9");

    // R6: duplicates, lowest index wins
    do_write(20, word(1, 16'h0555, rid(5, 5, 5)), "R6");
    do_write(12, word(1, 16'h0444, rid(5, 5, 5)), "R6");
    do_write(30, word(1, 16'h0666, rid(5, 5, 5)), "R6");
    do_lookup(rid(5, 5, 5), "R6");
    do_write(12, 32'h0, "R6");
    do_lookup(rid(5, 5, 5), "R6");

    // R5: disabled slot with matching ID, then clearing a live slot
    do_write(8, word(0, 16'h0777, rid(7, 7, 7)), "R5");
    do_lookup(rid(7, 7, 7), "R5");
    do_write(0, 32'h0, "R5");
    do_lookup(rid(1, 0, 0), "R5");

    // R7: miss pulse lasts one cycle; idle cycle has no error
    do_lookup(16'hdead, "R7");
    step("R7");
    do_lookup(16'hdead, "R7");
    do_lookup(rid(2, 31, 7), "R7");

    // R8: write and lookup/read in the same cycle see old contents
    wr = 1; idx = 6'd15; wdata = word(1, 16'h0321, rid(66, 3, 1));
    lk = 1; lrid = rid(66, 3, 1);
    step("R8");
    do_lookup(rid(66, 3, 1), "R8");
    wr = 1; rd = 1; idx = 6'd15; wdata = 32'h0;
    step("R8");
    do_read(15, "R8");
    do_lookup(rid(66, 3, 1), "R8");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule